// File: doc/BRIEF.md
# Serial Clock Synthesizer Loader

This block programs an external clock synthesizer over a bit-banged serial link. The link has three level outputs (a select line, a data line and a serial clock line) plus a one-cycle strobe that tells the downstream output register to take the current levels. A caller gives a 5-bit location address and a 13-bit program word through a valid/ready handshake. The block then runs the whole load sequence without further help.

Every level update is held for a programmable number of system clock cycles before its strobe. This gives the synthesizer the setup time it needs, so software does not have to count microseconds. The sequence has three parts:

- Two setup updates, with the select line low and then high.
- A three-bit header of 1, 0, 0. The final 0 marks a write.
- The address and then the program word, each sent least-significant bit first.

Each serial bit uses two strobed updates. The first places the data with the serial clock low. The second raises the serial clock and keeps the data. After the last strobe the block raises `done` for one cycle and accepts a new request.

Top module: `csl_serial_loader`

## Requirements
- R1: After synchronous reset, `req_ready` is 1 and `ser_sel`, `ser_data`, `ser_clk`, `ser_strobe` and `done` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until `done`. A request offered while `req_ready` is 0 is ignored and does not alter the frame in flight.
- R3: One accepted request produces exactly 44 strobes, each exactly one cycle wide.
- R4: The first strobe is high SETTLE_CYCLES cycles after the acceptance edge. Successive strobes are SETTLE_CYCLES+1 cycles apart. The three lines do not change during the SETTLE_CYCLES cycles before a strobe or during the strobe itself.
- R5: At strobe 1, `ser_sel`, `ser_data` and `ser_clk` are all 0. At strobe 2, `ser_sel` is 1 and `ser_data` and `ser_clk` are 0.
- R6: Serial bits 0, 1 and 2 (strobes 3 to 8) carry the header values 1, 0, 0, in that order.
- R7: Serial bits 3 to 7 carry `req_addr[0]` through `req_addr[4]`, in that order.
- R8: Serial bits 8 to 20 carry `req_word[0]` through `req_word[12]`, in that order.
- R9: Serial bit b is carried by two strobes: strobe 2b+3 with `ser_clk` 0, then strobe 2b+4 with `ser_clk` 1. Both strobes carry the same `ser_data` value.
- R10: `done` is high for exactly one cycle, in the cycle after the last strobe. `req_ready` is 1 in that same cycle.
- R11: `ser_sel` is 1 at every strobe from strobe 2 through strobe 44.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Loader idle, request can be taken |
| req_addr | input | 5 | Synthesizer location address |
| req_word | input | 13 | Synthesizer program word |
| ser_sel | output | 1 | Select level (0 for the first setup update, 1 for the rest of the frame) |
| ser_data | output | 1 | Serial data level |
| ser_clk | output | 1 | Serial clock level |
| ser_strobe | output | 1 | One-cycle latch pulse for the current levels |
| done | output | 1 | One-cycle pulse after the final strobe |

## Verification
The bench builds the loader with SETTLE_CYCLES set to 4 instead of the default of 3250 cycles, which is 26 µs at 125 MHz. A full frame then takes 220 cycles, so several address/word patterns fit in one run: all zeros, all ones, alternating patterns, and single set bits at each end of the address and the word. The same setting makes the exact strobe spacing, the first-strobe latency and the done timing easy to count cycle by cycle. A request held asserted in the middle of a frame, with inverted data, checks that work in flight cannot be disturbed.

// File: rtl/csl_pkg.sv
package csl_pkg;
  localparam int unsigned HDR_W        = 3;
  // header sent bit 0 first: 1, 0, 0 (last 0 = write)
  localparam logic [HDR_W-1:0] HDR_BITS = 3'b001;
  localparam int unsigned INIT_UPDATES = 2;
  localparam int unsigned DEF_ADDR_W   = 5;
  localparam int unsigned DEF_WORD_W   = 13;

  typedef struct packed {
    logic sel;
    logic data;
    logic sclk;
  } csl_lines_t;
endpackage

// File: rtl/csl_frame_pack.sv
module csl_frame_pack
  import csl_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned WORD_W  = DEF_WORD_W,
  localparam int unsigned FRAME_W = HDR_W + ADDR_W + WORD_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WORD_W-1:0]  word,
  output logic [FRAME_W-1:0] frame
);
  // bit 0 leaves first: header, then address LSB-first, then word LSB-first
  assign frame = {word, addr, HDR_BITS};
endmodule

// File: rtl/csl_lines_decode.sv
module csl_lines_decode
  import csl_pkg::*;
#(
  parameter int unsigned FRAME_W = 21,
  parameter int unsigned IDX_W   = 6
) (
  input  logic [FRAME_W-1:0] frame,
  input  logic [IDX_W-1:0]   idx,
  output csl_lines_t         lines
);
  logic [IDX_W-1:0] rel;
  logic [IDX_W-1:0] bit_sel;
  logic             bit_val;

  assign rel     = idx - IDX_W'(INIT_UPDATES);
  assign bit_sel = rel >> 1;

  always_comb begin
    bit_val = 1'b0;
    for (int b = 0; b < int'(FRAME_W); b++) begin
      if (bit_sel == IDX_W'(b)) bit_val = frame[b];
    end
  end

  always_comb begin
    lines.sel = (idx != '0);
    if (idx < IDX_W'(INIT_UPDATES)) begin
      lines.data = 1'b0;
      lines.sclk = 1'b0;
    end else begin
      lines.data = bit_val;
      lines.sclk = rel[0];
    end
  end
endmodule

// File: rtl/csl_settle_timer.sv
module csl_settle_timer #(
  parameter int unsigned LIMIT = 3250,
  localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic hit
);
  logic [CNT_W-1:0] cnt_q;

  assign hit = en && (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (hit)    cnt_q <= '0;
    else if (en)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/csl_serial_loader.sv
module csl_serial_loader
  import csl_pkg::*;
#(
  parameter int unsigned ADDR_W        = DEF_ADDR_W,
  parameter int unsigned WORD_W        = DEF_WORD_W,
  parameter int unsigned SETTLE_CYCLES = 3250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_word,
  output logic              ser_sel,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_strobe,
  output logic              done
);
  localparam int unsigned FRAME_W  = HDR_W + ADDR_W + WORD_W;
  localparam int unsigned LAST_UPD = INIT_UPDATES + 2 * FRAME_W - 1;
  localparam int unsigned IDX_W    = $clog2(LAST_UPD + 1);

  logic               ready_q, busy_q, strobe_q, done_q;
  logic [IDX_W-1:0]   idx_q, nxt_idx;
  logic [FRAME_W-1:0] frame_q, new_frame, frame_mux;
  csl_lines_t         lines_q, dec_lines;
  logic               accept, hit, last_upd;

  assign accept    = req_valid && ready_q;
  assign frame_mux = accept ? new_frame : frame_q;
  assign nxt_idx   = accept ? '0 : idx_q + 1'b1;
  assign last_upd  = (idx_q == IDX_W'(LAST_UPD));

  csl_frame_pack #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_pack (
    .addr  (req_addr),
    .word  (req_word),
    .frame (new_frame)
  );

  csl_lines_decode #(.FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_dec (
    .frame (frame_mux),
    .idx   (nxt_idx),
    .lines (dec_lines)
  );

  csl_settle_timer #(.LIMIT(SETTLE_CYCLES)) u_timer (
    .clk (clk),
    .rst (rst),
    .clr (!busy_q),
    .en  (busy_q && !strobe_q),
    .hit (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q  <= 1'b1;
      busy_q   <= 1'b0;
      strobe_q <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
      frame_q  <= '0;
      lines_q  <= '0;
    end else begin
      done_q   <= 1'b0;
      strobe_q <= hit;
      if (accept) begin
        ready_q <= 1'b0;
        busy_q  <= 1'b1;
        frame_q <= new_frame;
        idx_q   <= '0;
        lines_q <= dec_lines;
      end else if (strobe_q) begin
        if (last_upd) begin
          busy_q  <= 1'b0;
          ready_q <= 1'b1;
          done_q  <= 1'b1;
        end else begin
          idx_q   <= nxt_idx;
          lines_q <= dec_lines;
        end
      end
    end
  end

  assign req_ready  = ready_q;
  assign ser_sel    = lines_q.sel;
  assign ser_data   = lines_q.data;
  assign ser_clk    = lines_q.sclk;
  assign ser_strobe = strobe_q;
  assign done       = done_q;
endmodule

// File: rtl/csl_loader_checks.sv
module csl_loader_checks (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic ser_sel,
  input logic ser_data,
  input logic ser_clk,
  input logic ser_strobe,
  input logic done
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !ser_strobe && !done));

  a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r2_busy_at_strobe: assert property (@(posedge clk) disable iff (rst)
    ser_strobe |-> !req_ready);

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
    ser_strobe |=> !ser_strobe);

  a_r4_lines_hold: assert property (@(posedge clk) disable iff (rst)
    ser_strobe |-> ($stable(ser_data) && $stable(ser_clk) && $stable(ser_sel)));

  a_r9_clk_rise_keeps_data: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |-> $stable(ser_data));

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_ready: assert property (@(posedge clk) disable iff (rst)
    done |-> (req_ready && !ser_strobe));
endmodule

bind csl_serial_loader csl_loader_checks u_checks (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .ser_sel    (ser_sel),
  .ser_data   (ser_data),
  .ser_clk    (ser_clk),
  .ser_strobe (ser_strobe),
  .done       (done)
);

// File: tb/tb_csl_serial_loader.sv
`timescale 1ns/1ps
module tb_csl_serial_loader;
  localparam int S       = 4;
  localparam int NSTROBE = 44;
  localparam int NVEC    = 6;
  localparam logic [17:0] VEC [0:NVEC-1] = '{
    {5'h00, 13'h0000}, {5'h1F, 13'h1FFF}, {5'h15, 13'h0AAA},
    {5'h0A, 13'h1555}, {5'h01, 13'h1000}, {5'h10, 13'h0001}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [4:0]  req_addr = '0;
  logic [12:0] req_word = '0;
  logic ser_sel, ser_data, ser_clk, ser_strobe, done;

  int checks = 0;
  int fails  = 0;
  logic rs [0:NSTROBE-1];
  logic rd [0:NSTROBE-1];
  logic rc [0:NSTROBE-1];

  always #4 clk = ~clk;

  csl_serial_loader #(.SETTLE_CYCLES(S)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_word(req_word), .ser_sel(ser_sel),
    .ser_data(ser_data), .ser_clk(ser_clk), .ser_strobe(ser_strobe), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int b, input logic [4:0] a, input logic [12:0] w);
    if (b == 0) return 1'b1;
    if (b < 3)  return 1'b0;
    if (b < 8)  return a[b-3];
    return w[b-8];
  endfunction

  task automatic run_frame(input logic [4:0] a, input logic [12:0] w, input bit intrude);
    int ns = 0, last_n = 0, done_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_word = w;
    @(negedge clk);
    chk("R2 ready low after accept", int'(req_ready), 0);
    req_valid = 1'b0;
    if (intrude) begin req_valid = 1'b1; req_addr = ~a; req_word = ~w; end
    for (int n = 1; n <= NSTROBE * (S + 1) + 20 && done_n == 0; n++) begin
      if (intrude && n == 60) req_valid = 1'b0;
      if (ser_strobe) begin
        if (ns == 0) chk("R4 first strobe latency", n, S + 1);
        else         chk("R4 strobe spacing", n - last_n, S + 1);
        if (ns < NSTROBE) begin rs[ns] = ser_sel; rd[ns] = ser_data; rc[ns] = ser_clk; end
        ns++; last_n = n;
      end
      if (done) done_n = n;
      if (done_n == 0) @(negedge clk);
    end
    chk("R3 strobe count", ns, NSTROBE);
    chk("R10 done one cycle after last strobe", done_n, last_n + 1);
    chk("R10 ready with done", int'(req_ready), 1);
    @(negedge clk);
    chk("R10 done width", int'(done), 0);
    if (ns >= NSTROBE) begin
      chk("R5 setup strobe 1 sel", int'(rs[0]), 0);
      chk("R5 setup strobe 1 lines", int'({rd[0], rc[0]}), 0);
      chk("R5 setup strobe 2 sel", int'(rs[1]), 1);
      chk("R5 setup strobe 2 lines", int'({rd[1], rc[1]}), 0);
      for (int k = 2; k < NSTROBE; k++) begin
        int b = (k - 2) / 2;
        string tag = (b < 3) ? "R6 header" : (b < 8) ? "R7 address" : "R8 word";
        chk(tag, int'(rd[k]), int'(exp_bit(b, a, w)));
        chk("R9 clock phase", int'(rc[k]), (k - 2) % 2);
        chk("R11 select held", int'(rs[k]), 1);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 lines", int'({ser_sel, ser_data, ser_clk}), 0);
    chk("R1 strobe", int'(ser_strobe), 0);
    chk("R1 done", int'(done), 0);
    for (int i = 0; i < NVEC; i++)
      run_frame(VEC[i][17:13], VEC[i][12:0], 1'b0);
    // R2: request held during a busy frame with inverted data must not leak in
    run_frame(5'h13, 13'h0F0F, 1'b1);
    // reset in idle returns to R1 state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 ready after re-reset", int'(req_ready), 1);
    chk("R1 lines after re-reset", int'({ser_sel, ser_data, ser_clk}), 0);
    run_frame(5'h04, 13'h0100, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule